// File: doc/BRIEF.md
# Dual Alarm Matcher with Interrupt Routing

This block sits beside the timekeeping counters of a real-time clock. On every once-per-second update strobe it compares the freshly updated time and date against two programmable alarms. Each alarm byte carries a mask bit that removes its field from the compare, so one alarm can fire every second, every minute, or only on a full time-and-day match. The first alarm compares seconds, minutes, hours and day-or-date. The second alarm has no seconds byte and matches only at second zero.

A match sets a sticky flag. Software can clear a flag by writing 0 to it, and writing 1 leaves it as it was. A small control register holds two enables, a routing bit and a two-bit rate select. The routing bit decides how the two active-low, open-drain interrupt pins are used. In separate mode, each alarm drives its own pin. In shared mode, both alarms drive pin A and pin B carries a square wave.

The square wave is taken from a prescaler that counts rising edges of the 32.768 kHz reference. The update strobe clears the prescaler, so the square wave stays in phase with the seconds. The pin outputs are pull-low enables: a 1 means the pin is driven low.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, ctl_q reads 5'b11000, flag_q reads 00, and irq_a_pull reads 0. The ctl_q fields are: bits 4:3 rate, bit 2 routing, bit 1 alarm-2 enable, bit 0 alarm-1 enable.
- R2: Alarm 1 compares seconds, minutes and hours (bits 6:0 of its bytes against t_sec, t_min, t_hour) and day-or-date. A field whose byte has bit 7 set is ignored, whatever its value. With all four bytes masked, alarm 1 matches on every update.
- R3: Alarm 2 compares minutes, hours and day-or-date, and matches only when t_sec is 0. With all three bytes masked, it matches once a minute, at second 0.
- R4: In each day/date byte, bit 6 selects the compare target. When bit 6 is 1, bits 3:0 are compared with the weekday t_wday. When bit 6 is 0, bits 5:0 are compared with the date t_mday.
- R5: A compare takes effect only on a cycle with upd_tick high. A match sets the flag (flag_q bit 0 for alarm 1, bit 1 for alarm 2) in the following cycle. Without upd_tick, no flag is set.
- R6: A status write (st_we) clears each flag whose st_wd bit is 0 and leaves unchanged each flag whose bit is 1. Flags otherwise stay set. If a set and a clear of the same flag fall in one cycle, the set wins.
- R7: With the routing bit at 1, irq_a_pull is flag 1 AND enable 1, and irq_b_pull is flag 2 AND enable 2.
- R8: With the routing bit at 0, irq_a_pull is 1 when either alarm's flag and enable are both 1, and irq_b_pull is the inverse of sqw.
- R9: A set flag whose enable bit is 0 drives no pull on either pin.
- R10: The prescaler counts rising edges of ref_clk_lvl and is cleared by upd_tick. The sqw output depends on the rate field:
  - 00 selects ph_1hz.
  - 01 selects prescaler bit 2, which goes to 1 after the 4th edge.
  - 10 selects prescaler bit 1, which goes to 1 after the 2nd edge.
  - 11 follows ref_clk_lvl directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_tick | input | 1 | Once-per-second update strobe |
| ref_clk_lvl | input | 1 | 32.768 kHz reference level, synchronous to clk |
| ph_1hz | input | 1 | 1 Hz phase level |
| t_sec | input | 7 | Current seconds, BCD |
| t_min | input | 7 | Current minutes, BCD |
| t_hour | input | 7 | Current hour byte, bits 6:0 |
| t_wday | input | 3 | Day of week |
| t_mday | input | 6 | Date of month, BCD |
| al1_sec | input | 8 | Alarm 1 seconds, bit 7 is the mask |
| al1_min | input | 8 | Alarm 1 minutes, bit 7 is the mask |
| al1_hour | input | 8 | Alarm 1 hours, bit 7 is the mask |
| al1_dd | input | 8 | Alarm 1 day/date: bit 7 mask, bit 6 day select |
| al2_min | input | 8 | Alarm 2 minutes, bit 7 is the mask |
| al2_hour | input | 8 | Alarm 2 hours, bit 7 is the mask |
| al2_dd | input | 8 | Alarm 2 day/date: bit 7 mask, bit 6 day select |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wd | input | 5 | Control write data |
| st_we | input | 1 | Status (flag) write strobe |
| st_wd | input | 2 | Flag write data; a 0 bit clears that flag |
| ctl_q | output | 5 | Control register value |
| flag_q | output | 2 | Alarm flags {alarm 2, alarm 1} |
| irq_a_pull | output | 1 | Pin A pull-low enable |
| irq_b_pull | output | 1 | Pin B pull-low enable |
| sqw | output | 1 | Selected square-wave level |

## Verification
A table of time-and-alarm vectors is applied, each with one update strobe. The table covers the following patterns:
- all fields masked, on a non-zero second and on second zero, which separates the alarm-1 every-second rate from the alarm-2 once-a-minute rate;
- single-field and multi-field matches;
- a masked field that holds a wrong value, which shows the mask truly removes the field;
- day-select against date-select, using a value that would match only under the other target.

Directed tests then cover the following:
- a matching alarm with no strobe, which shows the compare happens only on the update;
- writes of 0 and 1 to the flags, and a set and a clear in the same cycle, which show which one wins;
- each routing and enable combination;
- each rate tap, counted in reference edges after a prescaler clear, which tells the divided rates apart from the direct ones.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam int N_ALARM  = 2;
   localparam int ABYTE_W  = 8;
   localparam int ABYTES   = 4;
   localparam int CTL_W    = 5;
   localparam int CTL_EN0  = 0;
   localparam int CTL_ROUTE = 2;
   localparam int CTL_RATE = 3;
   localparam int MASK_BIT = 7;
   localparam int DSEL_BIT = 6;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [6:0] hour;
      logic [2:0] wday;
      logic [5:0] mday;
   } tod_t;

   typedef enum logic [1:0] {
      RATE_1HZ = 2'b00,
      RATE_4K  = 2'b01,
      RATE_8K  = 2'b10,
      RATE_32K = 2'b11
   } rate_e;
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp
   import rtc_alarm_pkg::*;
#(
   parameter bit HAS_SEC = 1'b1
) (
   input  tod_t               now,
   input  logic [ABYTE_W-1:0] a_sec,
   input  logic [ABYTE_W-1:0] a_min,
   input  logic [ABYTE_W-1:0] a_hour,
   input  logic [ABYTE_W-1:0] a_dd,
   output logic               hit
);
   logic sec_ok, min_ok, hour_ok, dd_ok, dd_eq;

   generate
      if (HAS_SEC) begin : g_sec
         assign sec_ok = a_sec[MASK_BIT] | (a_sec[6:0] == now.sec);
      end else begin : g_nosec
         logic unused_sec;
         assign unused_sec = ^a_sec;
         assign sec_ok = (now.sec == 7'd0);
      end
   endgenerate

   assign min_ok  = a_min[MASK_BIT]  | (a_min[6:0]  == now.min);
   assign hour_ok = a_hour[MASK_BIT] | (a_hour[6:0] == now.hour);
   assign dd_eq   = a_dd[DSEL_BIT] ? (a_dd[3:0] == {1'b0, now.wday})
                                   : (a_dd[5:0] == now.mday);
   assign dd_ok   = a_dd[MASK_BIT] | dd_eq;
   assign hit     = sec_ok & min_ok & hour_ok & dd_ok;
endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
   import rtc_alarm_pkg::*;
#(
   parameter int PRESC_W = 3
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ref_lvl,
   input  logic  ph_1hz,
   input  logic  align,
   input  rate_e rate,
   output logic  sqw
);
   localparam int TAP_4K = PRESC_W - 1;
   localparam int TAP_8K = PRESC_W - 2;

   logic               ref_q;
   logic [PRESC_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
         div_q <= '0;
      end else begin
         ref_q <= ref_lvl;
         if (align)
            div_q <= '0;
         else if (ref_lvl && !ref_q)
            div_q <= div_q + 1'b1;
      end
   end

   always_comb begin
      unique case (rate)
         RATE_1HZ: sqw = ph_1hz;
         RATE_4K:  sqw = div_q[TAP_4K];
         RATE_8K:  sqw = div_q[TAP_8K];
         default:  sqw = ref_lvl;
      endcase
   end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alarm_pkg::*;
#(
   parameter int              PRESC_W   = 3,
   parameter logic [CTL_W-1:0] RESET_CTL = 5'b11000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_tick,
   input  logic               ref_clk_lvl,
   input  logic               ph_1hz,
   input  logic [6:0]         t_sec,
   input  logic [6:0]         t_min,
   input  logic [6:0]         t_hour,
   input  logic [2:0]         t_wday,
   input  logic [5:0]         t_mday,
   input  logic [7:0]         al1_sec,
   input  logic [7:0]         al1_min,
   input  logic [7:0]         al1_hour,
   input  logic [7:0]         al1_dd,
   input  logic [7:0]         al2_min,
   input  logic [7:0]         al2_hour,
   input  logic [7:0]         al2_dd,
   input  logic               ctl_we,
   input  logic [CTL_W-1:0]   ctl_wd,
   input  logic               st_we,
   input  logic [N_ALARM-1:0] st_wd,
   output logic [CTL_W-1:0]   ctl_q,
   output logic [N_ALARM-1:0] flag_q,
   output logic               irq_a_pull,
   output logic               irq_b_pull,
   output logic               sqw
);
   generate
      if (PRESC_W < 2) begin : g_bad_presc
         $error("PRESC_W must be at least 2");
      end
   endgenerate

   tod_t               now;
   logic [ABYTE_W-1:0] cfg [N_ALARM][ABYTES];
   logic [N_ALARM-1:0] hit, act, en;
   logic               route;

   assign now = '{sec: t_sec, min: t_min, hour: t_hour, wday: t_wday, mday: t_mday};
   assign cfg[0] = '{al1_sec, al1_min, al1_hour, al1_dd};
   assign cfg[1] = '{8'h80, al2_min, al2_hour, al2_dd};

   generate
      for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
         alarm_cmp #(.HAS_SEC(g == 0)) i_cmp (
            .now    (now),
            .a_sec  (cfg[g][0]),
            .a_min  (cfg[g][1]),
            .a_hour (cfg[g][2]),
            .a_dd   (cfg[g][3]),
            .hit    (hit[g])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag_q[g] <= 1'b0;
            else
               flag_q[g] <= (flag_q[g] & ~(st_we & ~st_wd[g])) | (upd_tick & hit[g]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= RESET_CTL;
      else if (ctl_we)
         ctl_q <= ctl_wd;
   end

   assign en    = ctl_q[CTL_EN0 +: N_ALARM];
   assign route = ctl_q[CTL_ROUTE];
   assign act   = flag_q & en;

   sqw_gen #(.PRESC_W(PRESC_W)) i_sqw (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_lvl (ref_clk_lvl),
      .ph_1hz  (ph_1hz),
      .align   (upd_tick),
      .rate    (rate_e'(ctl_q[CTL_RATE +: 2])),
      .sqw     (sqw)
   );

   assign irq_a_pull = act[0] | (~route & act[1]);
   assign irq_b_pull = route ? act[1] : ~sqw;
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       upd_tick,
   input logic       st_we,
   input logic [1:0] st_wd,
   input logic [4:0] ctl_q,
   input logic [1:0] flag_q,
   input logic       irq_a_pull,
   input logic       irq_b_pull
);
   // R5
   flag1_rise_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[0]) |-> $past(upd_tick));
   // R5
   flag2_rise_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[1]) |-> $past(upd_tick));
   // R6
   flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[0] && !(st_we && !st_wd[0])) |=> flag_q[0]);
   // R6
   flag2_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && !st_wd[1] && !upd_tick) |=> !flag_q[1]);
   // R9
   pin_a_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a_pull |-> ((flag_q[0] && ctl_q[0]) || (flag_q[1] && ctl_q[1])));
   // R7
   pin_b_separate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[2] && irq_b_pull) |-> (flag_q[1] && ctl_q[1]));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_tick   (upd_tick),
   .st_we      (st_we),
   .st_wd      (st_wd),
   .ctl_q      (ctl_q),
   .flag_q     (flag_q),
   .irq_a_pull (irq_a_pull),
   .irq_b_pull (irq_b_pull)
);

// File: tb/test_rtc_alarm_irq.sv
module test_rtc_alarm_irq;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd_tick = 1'b0, ref_clk_lvl = 1'b0, ph_1hz = 1'b0;
   logic [6:0] t_sec = '0, t_min = '0, t_hour = '0;
   logic [2:0] t_wday = '0;
   logic [5:0] t_mday = '0;
   logic [7:0] al1_sec = 8'h80, al1_min = 8'h80, al1_hour = 8'h80, al1_dd = 8'h80;
   logic [7:0] al2_min = 8'h80, al2_hour = 8'h80, al2_dd = 8'h80;
   logic       ctl_we = 1'b0, st_we = 1'b0;
   logic [4:0] ctl_wd = '0;
   logic [1:0] st_wd = '0;
   logic [4:0] ctl_q;
   logic [1:0] flag_q;
   logic       irq_a_pull, irq_b_pull, sqw;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_alarm_irq i_rtc_alarm_irq (.*);

   typedef struct packed {
      logic [6:0] sec; logic [6:0] min; logic [6:0] hour;
      logic [2:0] wday; logic [5:0] mday;
      logic [7:0] a1s; logic [7:0] a1m; logic [7:0] a1h; logic [7:0] a1d;
      logic [7:0] a2m; logic [7:0] a2h; logic [7:0] a2d;
      logic [1:0] exp;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{7'h45, 7'h30, 7'h12, 3'd3, 6'h15, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 2'b01},
      '{7'h00, 7'h31, 7'h12, 3'd3, 6'h15, 8'h00, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 2'b11},
      '{7'h45, 7'h30, 7'h12, 3'd3, 6'h15, 8'h45, 8'h30, 8'h12, 8'h80, 8'h30, 8'h80, 8'h80, 2'b01},
      '{7'h00, 7'h30, 7'h12, 3'd3, 6'h15, 8'h45, 8'h30, 8'h12, 8'h80, 8'h30, 8'h12, 8'h80, 2'b10},
      '{7'h00, 7'h15, 7'h08, 3'd5, 6'h21, 8'h00, 8'h15, 8'h08, 8'h45, 8'h15, 8'h08, 8'h21, 2'b11},
      '{7'h00, 7'h15, 7'h08, 3'd5, 6'h21, 8'h00, 8'h15, 8'h08, 8'h05, 8'h15, 8'h08, 8'h45, 2'b10},
      '{7'h59, 7'h59, 7'h23, 3'd1, 6'h31, 8'h59, 8'h59, 8'h85, 8'h80, 8'h59, 8'h22, 8'h80, 2'b01},
      '{7'h59, 7'h59, 7'h23, 3'd1, 6'h31, 8'h59, 8'h58, 8'h80, 8'h80, 8'h59, 8'h23, 8'h80, 2'b00}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic upd();
      @(negedge clk) upd_tick = 1'b1;
      @(negedge clk) upd_tick = 1'b0;
   endtask

   task automatic st_write(input logic [1:0] wd);
      @(negedge clk) begin st_we = 1'b1; st_wd = wd; end
      @(negedge clk) st_we = 1'b0;
   endtask

   task automatic ctl_write(input logic [4:0] wd);
      @(negedge clk) begin ctl_we = 1'b1; ctl_wd = wd; end
      @(negedge clk) ctl_we = 1'b0;
   endtask

   task automatic ref_edge();
      @(negedge clk) ref_clk_lvl = 1'b1;
      @(negedge clk) ref_clk_lvl = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 3);
      @(negedge clk);
      check("R1 reset ctl", ctl_q, 5'b11000);
      check("R1 reset flags", flag_q, 2'b00);
      check("R1 reset pin A", irq_a_pull, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 R3 R4 R5
      for (int i = 0; i < 8; i++) begin
         st_write(2'b00);
         @(negedge clk) begin
            t_sec = TBL[i].sec; t_min = TBL[i].min; t_hour = TBL[i].hour;
            t_wday = TBL[i].wday; t_mday = TBL[i].mday;
            al1_sec = TBL[i].a1s; al1_min = TBL[i].a1m;
            al1_hour = TBL[i].a1h; al1_dd = TBL[i].a1d;
            al2_min = TBL[i].a2m; al2_hour = TBL[i].a2h; al2_dd = TBL[i].a2d;
         end
         upd();
         check($sformatf("R2 R3 R4 vector %0d flags", i), flag_q, TBL[i].exp);
      end

      // R5: matching alarms but no update strobe
      st_write(2'b00);
      @(negedge clk) begin
         t_sec = 7'h00; al1_sec = 8'h80; al1_min = 8'h80; al1_hour = 8'h80; al1_dd = 8'h80;
         al2_min = 8'h80; al2_hour = 8'h80; al2_dd = 8'h80;
      end
      repeat (3) @(negedge clk);
      check("R5 no strobe no flag", flag_q, 2'b00);
      upd();
      check("R5 strobe sets flags", flag_q, 2'b11);

      // R6
      st_write(2'b11);
      check("R6 write ones keeps flags", flag_q, 2'b11);
      st_write(2'b01);
      check("R6 clear flag 2 only", flag_q, 2'b01);
      st_write(2'b00);
      check("R6 clear all", flag_q, 2'b00);
      @(negedge clk) begin upd_tick = 1'b1; st_we = 1'b1; st_wd = 2'b00; end
      @(negedge clk) begin upd_tick = 1'b0; st_we = 1'b0; end
      check("R6 set wins over clear", flag_q, 2'b11);

      // R7: separate routing, both enabled
      ctl_write(5'b11111);
      check("R7 pin A from flag 1", irq_a_pull, 1'b1);
      check("R7 pin B from flag 2", irq_b_pull, 1'b1);
      st_write(2'b10);
      check("R7 pin A released", irq_a_pull, 1'b0);
      check("R7 pin B held", irq_b_pull, 1'b1);

      // R8: shared routing, square wave on B (rate 11 follows reference)
      ctl_write(5'b11011);
      check("R8 pin A from flag 2", irq_a_pull, 1'b1);
      @(negedge clk) ref_clk_lvl = 1'b1;
      #1 check("R8 pin B low pull off when wave high", irq_b_pull, 1'b0);
      check("R10 rate 11 follows ref high", sqw, 1'b1);
      @(negedge clk) ref_clk_lvl = 1'b0;
      #1 check("R8 pin B pulls when wave low", irq_b_pull, 1'b1);
      check("R10 rate 11 follows ref low", sqw, 1'b0);

      // R9: enables off, flag 2 still set
      ctl_write(5'b11000);
      check("R9 flag kept while disabled", flag_q, 2'b10);
      check("R9 disabled pin A", irq_a_pull, 1'b0);
      ctl_write(5'b11100);
      check("R9 disabled pin B", irq_b_pull, 1'b0);

      // R10: divided rates
      ctl_write(5'b01100);
      upd();
      repeat (3) ref_edge();
      check("R10 rate 01 after 3 edges", sqw, 1'b0);
      ref_edge();
      check("R10 rate 01 after 4 edges", sqw, 1'b1);
      ctl_write(5'b10100);
      upd();
      ref_edge();
      check("R10 rate 10 after 1 edge", sqw, 1'b0);
      ref_edge();
      check("R10 rate 10 after 2 edges", sqw, 1'b1);
      upd();
      check("R10 strobe clears prescaler", sqw, 1'b0);
      ctl_write(5'b00100);
      @(negedge clk) ph_1hz = 1'b1;
      #1 check("R10 rate 00 follows 1 Hz phase", sqw, 1'b1);
      @(negedge clk) ph_1hz = 1'b0;
      #1 check("R10 rate 00 phase low", sqw, 1'b0);

      finish_run();
   end
endmodule